// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator as two 32-bit words, a high word and a low word, and adds a signed product to it whenever an operation is issued. Two product forms exist. The long form multiplies the full 32-bit operands as signed numbers. The word form multiplies only the low 16 bits of each operand, also as signed numbers. With the saturation input low, the 64-bit sum is written back with two's-complement wraparound. With it high, each form applies its own clamp after the add. The two clamps follow different rules.

Software-visible state is changed in three ways. A clear strobe zeroes both words. Two direct load ports each overwrite one word. An accumulate request uses the product. Clear wins over everything. A load wins over an accumulate issued in the same cycle, and that accumulate is dropped. The result is registered. A one-cycle completion flag follows every accepted accumulate.

A two-state controller tracks completion. `ST_IDLE` is the resting state. `ST_RESULT` means a result was written on the last edge. The transition `GO_RESULT` (IDLE to RESULT) and the transition `STAY_RESULT` (RESULT to RESULT) are taken on an accepted accumulate. The transition `BACK_IDLE` (RESULT to IDLE) is taken on any cycle without one. An idle cycle stays in `ST_IDLE`.

Top module: `smac_unit`

## Requirements
- R1: After reset both accumulator words read 0 and `mac_done` is 0.
- R2: `acc_clr` high at a clock edge sets both words to 0 on that edge. It overrides any load or accumulate in the same cycle, and no `mac_done` follows.
- R3: `hi_load`/`lo_load` high at an edge (without `acc_clr`) write `hi_load_val`/`lo_load_val` into that word. The other word is unchanged. An accumulate requested in the same cycle is discarded, and no `mac_done` follows.
- R4: Long form (`op_word`=0), `sat_mode`=0: {hi,lo} becomes {hi,lo} + sext64(a)*sext64(b), modulo 2^64.
- R5: Word form (`op_word`=1), `sat_mode`=0: {hi,lo} becomes {hi,lo} + sext64(a[15:0])*sext64(b[15:0]) modulo 2^64. Operand bits 31:16 have no effect.
- R6: Long form, `sat_mode`=1, 64-bit sum negative: the written high word has bits 31:16 forced to 1, with bits 15:0 and the low word taken from the sum.
- R7: Long form, `sat_mode`=1, sum non-negative: the written high word keeps only bits 14:0 of the sum's high word (bits 31:15 zero), and the low word is the sum's low word.
- R8: Word form, `sat_mode`=1, sum below -2^31: high word becomes 1 and low word becomes 0x80000000.
- R9: Word form, `sat_mode`=1, sum above 2^31-1: high word becomes 1 and low word becomes 0x7FFFFFFF. A sum within [-2^31, 2^31-1] is written unchanged.
- R10: `mac_done` is 1 in exactly the cycle after each accepted accumulate (`mac_go` high, no clear, no load). In a cycle with no clear, load or accepted accumulate, both words keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_go | input | 1 | Accumulate request strobe |
| op_word | input | 1 | 0 = long form, 1 = word (16-bit) form |
| sat_mode | input | 1 | 1 = apply clamp of the selected form |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| acc_clr | input | 1 | Clear both accumulator words |
| hi_load | input | 1 | Load high word |
| hi_load_val | input | 32 | Value for high-word load |
| lo_load | input | 1 | Load low word |
| lo_load_val | input | 32 | Value for low-word load |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |
| mac_done | output | 1 | Completion pulse, one cycle after an accepted accumulate |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its stimulus is presented. This holds for accumulated words, loaded words, cleared words and the `mac_done` flag alike. The driver records the due cycle with each expected item. The monitor compares only on the falling edge of that cycle, after the register has settled and before the next stimulus lands. Back-to-back requests are therefore checked one per cycle, in issue order.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic {
        OP_LONG = 1'b0,
        OP_WORD = 1'b1
    } mac_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } mac_state_e;

endpackage

// File: rtl/smac_mult.sv
module smac_mult #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0]   a_in,
    input  logic [DW-1:0]   b_in,
    input  smac_pkg::mac_op_e op,
    output logic [2*DW-1:0] prod
);
    localparam int AW = 2 * DW;

    logic signed [AW-1:0] a_full, b_full, a_half, b_half;
    logic signed [AW-1:0] p_full, p_half;

    // sign extension of the complete operands and of their low halves
    assign a_full = {{DW{a_in[DW-1]}}, a_in};
    assign b_full = {{DW{b_in[DW-1]}}, b_in};
    assign a_half = {{(AW-HW){a_in[HW-1]}}, a_in[HW-1:0]};
    assign b_half = {{(AW-HW){b_in[HW-1]}}, b_in[HW-1:0]};

    assign p_full = a_full * b_full;
    assign p_half = a_half * b_half;

    always_comb begin
        unique case (op)
            smac_pkg::OP_LONG: prod = p_full;
            smac_pkg::OP_WORD: prod = p_half;
            default:           prod = p_full;
        endcase
    end
endmodule

// File: rtl/smac_sat.sv
module smac_sat #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [2*DW-1:0]   sum,
    input  smac_pkg::mac_op_e op,
    input  logic              sat_on,
    output logic [DW-1:0]     res_hi,
    output logic [DW-1:0]     res_lo
);
    localparam int AW = 2 * DW;
    // long-form masks on the high word
    localparam logic [DW-1:0] NEG_SET  = {{(DW-HW){1'b1}}, {HW{1'b0}}};
    localparam logic [DW-1:0] POS_KEEP = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
    // word-form limits as 64-bit signed values
    localparam logic signed [AW-1:0] W_MIN = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [AW-1:0] W_MAX = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] LO_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LO_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MARK   = {{(DW-1){1'b0}}, 1'b1};

    logic signed [AW-1:0] s_sgn;
    logic                 is_neg, below, above;
    logic [DW-1:0]        sum_hi, sum_lo;

    assign s_sgn  = sum;
    assign sum_hi = sum[AW-1:DW];
    assign sum_lo = sum[DW-1:0];
    assign is_neg = sum[AW-1];
    assign below  = s_sgn < W_MIN;
    assign above  = s_sgn > W_MAX;

    always_comb begin
        res_hi = sum_hi;
        res_lo = sum_lo;
        if (sat_on) begin
            unique case (op)
                smac_pkg::OP_LONG: begin
                    if (is_neg) res_hi = sum_hi | NEG_SET;
                    else        res_hi = sum_hi & POS_KEEP;
                end
                smac_pkg::OP_WORD: begin
                    if (below) begin
                        res_hi = MARK;
                        res_lo = LO_MIN;
                    end else if (above) begin
                        res_hi = MARK;
                        res_lo = LO_MAX;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smac_ctrl.sv
module smac_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic clr_req,
    input  logic load_req,
    output logic acc_go,
    output logic done
);
    import smac_pkg::*;

    mac_state_e state_q, state_d;

    assign acc_go = go_req && !clr_req && !load_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: GO_RESULT / STAY_RESULT on acc_go, BACK_IDLE otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = acc_go ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = acc_go ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   done = 1'b0;
            ST_RESULT: done = 1'b1;
            default:   done = 1'b0;
        endcase
    end
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mac_go,
    input  logic          op_word,
    input  logic          sat_mode,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          acc_clr,
    input  logic          hi_load,
    input  logic [DW-1:0] hi_load_val,
    input  logic          lo_load,
    input  logic [DW-1:0] lo_load_val,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo,
    output logic          mac_done
);
    import smac_pkg::*;
    localparam int AW = 2 * DW;

    mac_op_e        op_sel;
    logic [AW-1:0]  prod, sum;
    logic [DW-1:0]  nxt_hi, nxt_lo;
    logic           acc_go;

    assign op_sel = op_word ? OP_WORD : OP_LONG;

    smac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_req   (mac_go),
        .clr_req  (acc_clr),
        .load_req (hi_load | lo_load),
        .acc_go   (acc_go),
        .done     (mac_done)
    );

    smac_mult #(.DW(DW), .HW(HW)) u_mult (
        .a_in (opnd_a),
        .b_in (opnd_b),
        .op   (op_sel),
        .prod (prod)
    );

    assign sum = {acc_hi, acc_lo} + prod;

    smac_sat #(.DW(DW), .HW(HW)) u_sat (
        .sum    (sum),
        .op     (op_sel),
        .sat_on (sat_mode),
        .res_hi (nxt_hi),
        .res_lo (nxt_lo)
    );

    // accumulator words: clear > loads > accumulate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (acc_clr) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (hi_load || lo_load) begin
            if (hi_load) acc_hi <= hi_load_val;
            if (lo_load) acc_lo <= lo_load_val;
        end else if (acc_go) begin
            acc_hi <= nxt_hi;
            acc_lo <= nxt_lo;
        end
    end
endmodule

// File: rtl/smac_chk.sv
module smac_chk #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mac_go,
    input logic          op_word,
    input logic          sat_mode,
    input logic          acc_clr,
    input logic          hi_load,
    input logic [DW-1:0] hi_load_val,
    input logic          lo_load,
    input logic [DW-1:0] lo_load_val,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo,
    input logic          mac_done
);
    localparam logic [DW-1:0] LO_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LO_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MARK   = {{(DW-1){1'b0}}, 1'b1};

    logic accepted, anyload;
    assign anyload  = hi_load || lo_load;
    assign accepted = mac_go && !acc_clr && !anyload;

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0 && !mac_done));

    p_load_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && hi_load) |=> acc_hi == $past(hi_load_val));

    p_load_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && lo_load) |=> acc_lo == $past(lo_load_val));

    p_load_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && anyload) |=> !mac_done);

    p_long_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !op_word && sat_mode) |=>
            (acc_hi[DW-1:HW] == '1 || acc_hi[DW-1:HW-1] == '0));

    p_word_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && op_word && sat_mode) |=>
            (acc_hi == '0 || acc_hi == '1 || acc_hi == MARK));

    p_word_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && op_word && sat_mode) |=>
            (acc_hi != MARK || acc_lo == LO_MIN || acc_lo == LO_MAX));

    p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> mac_done);

    p_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accepted |=> !mac_done);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!accepted && !acc_clr && !anyload) |=> ($stable(acc_hi) && $stable(acc_lo)));
endmodule

bind smac_unit smac_chk #(.DW(DW), .HW(HW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mac_go      (mac_go),
    .op_word     (op_word),
    .sat_mode    (sat_mode),
    .acc_clr     (acc_clr),
    .hi_load     (hi_load),
    .hi_load_val (hi_load_val),
    .lo_load     (lo_load),
    .lo_load_val (lo_load_val),
    .acc_hi      (acc_hi),
    .acc_lo      (acc_lo),
    .mac_done    (mac_done)
);

// File: tb/smac_unit_tb_top.sv
`timescale 1ns/1ps
module smac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_go = 0, op_word = 0, sat_mode = 0;
    logic [31:0] opnd_a = 0, opnd_b = 0;
    logic        acc_clr = 0, hi_load = 0, lo_load = 0;
    logic [31:0] hi_load_val = 0, lo_load_val = 0;
    logic [31:0] acc_hi, acc_lo;
    logic        mac_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 0;

    typedef struct {
        int          due;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        done;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    logic [31:0] m_hi = 0, m_lo = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    smac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mac_go(mac_go), .op_word(op_word),
        .sat_mode(sat_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_clr(acc_clr), .hi_load(hi_load), .hi_load_val(hi_load_val),
        .lo_load(lo_load), .lo_load_val(lo_load_val),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .mac_done(mac_done)
    );

    task automatic check(string tag, logic [31:0] h, logic [31:0] l, logic d,
                         logic [31:0] eh, logic [31:0] el, logic ed);
        n_tests++;
        if (h !== eh || l !== el || d !== ed) begin
            n_fail++;
            $display("FAIL %s: got hi=%08h lo=%08h done=%0b exp hi=%08h lo=%08h done=%0b",
                     tag, h, l, d, eh, el, ed);
        end
    endtask

    // monitor: compare items in the cycle they are due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.tag, acc_hi, acc_lo, mac_done, e.hi, e.lo, e.done);
        end
    end

    // driver: apply one cycle of stimulus and push the expected result
    task automatic issue(bit c, bit lh, logic [31:0] hv, bit ll, logic [31:0] lv,
                         bit st, bit wd, bit sat, logic [31:0] a, logic [31:0] b,
                         string tag);
        longint acc, p, sum;
        logic [63:0] su;
        logic [31:0] nh, nl;
        exp_t e;
        @(negedge clk);
        acc_clr = c; hi_load = lh; hi_load_val = hv; lo_load = ll; lo_load_val = lv;
        mac_go = st; op_word = wd; sat_mode = sat; opnd_a = a; opnd_b = b;
        e.done = 1'b0;
        if (c) begin
            m_hi = 0; m_lo = 0;
        end else if (lh || ll) begin
            if (lh) m_hi = hv;
            if (ll) m_lo = lv;
        end else if (st) begin
            acc = longint'({m_hi, m_lo});
            if (wd) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            else    p = longint'($signed(a)) * longint'($signed(b));
            sum = acc + p;
            su = sum;
            nh = su[63:32]; nl = su[31:0];
            if (sat && !wd) begin
                if (sum < 0) nh = nh | 32'hFFFF_0000;
                else         nh = nh & 32'h0000_7FFF;
            end else if (sat && wd) begin
                if (sum < -(longint'(1) << 31)) begin
                    nh = 32'd1; nl = 32'h8000_0000;
                end else if (sum > ((longint'(1) << 31) - 1)) begin
                    nh = 32'd1; nl = 32'h7FFF_FFFF;
                end
            end
            m_hi = nh; m_lo = nl;
            e.done = 1'b1;
        end
        e.due = cyc + 1; e.hi = m_hi; e.lo = m_lo; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(string tag);
        issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic lload(logic [31:0] h, logic [31:0] l, string tag);
        issue(0, 1, h, 1, l, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic mac(bit wd, bit sat, logic [31:0] a, logic [31:0] b, string tag);
        issue(0, 0, 0, 0, 0, 1, wd, sat, a, b, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        if (!finished) begin
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", acc_hi, acc_lo, mac_done, 0, 0, 0);

        // R4 long form, wraparound
        mac(0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 long max*max");
        mac(0, 0, 32'hFFFF_FFFD, 32'h0000_0005, "R4 long neg product");
        lload(32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3 load both words");
        mac(0, 0, 32'd1, 32'd1, "R4 long wrap");
        // R5 word form ignores upper bits
        issue(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 clear");
        mac(1, 0, 32'hABCD_8000, 32'h1234_0002, "R5 word low halves");
        mac(1, 0, 32'hFFFF_0003, 32'h0000_0004, "R5 word upper ignored");
        // R6 long sat negative
        lload(32'h8000_1234, 32'h0, "R3 load for R6");
        mac(0, 1, 32'd1, 32'd1, "R6 long sat negative");
        // R7 long sat non-negative
        lload(32'h1234_5678, 32'h0, "R3 load for R7");
        mac(0, 1, 32'd2, 32'd3, "R7 long sat positive");
        // R8 word sat below
        lload(32'hFFFF_FFFF, 32'h8000_0000, "R3 load for R8");
        mac(1, 1, 32'h0000_FFFF, 32'd1, "R8 word sat below");
        // R9 word sat above and in range
        lload(32'h0, 32'h7FFF_FFFF, "R3 load for R9");
        mac(1, 1, 32'd1, 32'd1, "R9 word sat above");
        issue(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 clear before in-range");
        mac(1, 1, 32'd100, 32'h0000_FFFD, "R9 word sat in range");
        // R3 load beats accumulate
        issue(0, 1, 32'hCAFE_0001, 0, 0, 1, 0, 0, 32'd7, 32'd9, "R3 load drops accumulate");
        issue(0, 0, 0, 1, 32'h0000_0010, 1, 1, 0, 32'd7, 32'd9, "R3 low load drops accumulate");
        // R2 clear beats load and accumulate
        issue(1, 1, 32'h1111_1111, 1, 32'h2222_2222, 1, 0, 0, 32'd3, 32'd3, "R2 clear priority");
        // R10 back-to-back and idle hold
        mac(0, 0, 32'd6, 32'd7, "R10 first of pair");
        mac(1, 0, 32'd2, 32'd5, "R10 second of pair");
        idle("R10 idle hold no done");
        idle("R10 idle hold again");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule